// File: doc/BRIEF.md
# Accumulator-Steered Dual-Modulus Clock Divider

This block divides a fast input clock by a ratio that is a fraction on average. Every output period is an integer count of input clocks: either N or N+1. A first-order phase accumulator chooses between the two, once per output period. The accumulator adds the m-bit fractional word x to its residue. When that sum overflows, the carry selects N+1 for the coming period. Over time the mean ratio settles at N + x/2^m.

The carry (the modulus bit of the current period) and the accumulator residue are both outputs. The residue is the running quantization phase error. It climbs while periods of length N run and drops back when a period of length N+1 occurs, so it traces the familiar fractional ramp.

N and x are sampled only at the terminal count of a period. A caller may change them at any time without corrupting the period in progress. The divided clock is high for a fixed number of input clocks at the start of each period, whatever the modulus.

Top module: `frac_modulus_divider`

## Requirements
- R1: Each output period lasts exactly N + c input clocks, where c is the carry output shown during that period.
- R2: At each period start, the sum of the previous residue and x (m+1 bits wide) is formed. Its top bit becomes the carry output and its low m bits become the residue output. Neither changes at any other time.
- R3: With x = 0 the carry output is never 1, and every period is N clocks long.
- R4: Over any 2^m consecutive periods with N and x held constant, the total length is exactly 2^m·N + x input clocks.
- R5: With m = 4 and x = 4, starting from reset, the carry over the first eight periods is 0,0,0,1,0,0,0,1.
- R6: The divided output is high for exactly HI_CYCLES clocks at the start of every period, for both N and N+1 periods.
- R7: N and x are sampled only on the clock edge that starts a period. A change made mid-period has no effect on that period's length.
- R8: While the synchronous reset is high, the divided output, carry and residue are all 0. The first period starts on the first clock edge after reset is released.
- R9: Legal N lies in HI_CYCLES+1 .. 2^N_WIDTH-1, and x lies in 0 .. 2^m-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| n_int | input | N_WIDTH | Integer part N of the ratio |
| x_frac | input | FRAC_WIDTH | Fractional word x; the ratio is N + x/2^m |
| div_clk | output | 1 | Divided clock, registered |
| mod_sel | output | 1 | Carry: 1 when the current period is N+1 long |
| phase_res | output | FRAC_WIDTH | Accumulator residue (quantization phase error) |

## Verification
A corrupted residue does not wait to be seen. It shows on `phase_res` at the next period start, one output period later at most. Its effect on the carry pattern then shifts which later periods come out N+1 long.

A wrong counter length or load value shows as a period that is off by a clock, and this is visible at the next rising edge of `div_clk`. A mistake in the high-time logic shows in the same period.

Because the bench models N and x as sampled at the period-starting edge, a design that latches them early or late produces a length mismatch within one period of any mid-period change.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int DEF_N_WIDTH    = 8;
  localparam int DEF_FRAC_WIDTH = 4;
  localparam int DEF_HI_CYCLES  = 2;
endpackage

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int FRAC_WIDTH = fdiv_pkg::DEF_FRAC_WIDTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  input  logic [FRAC_WIDTH-1:0] frac,
  output logic                  carry_nx,
  output logic                  carry_q,
  output logic [FRAC_WIDTH-1:0] resid_q
);
  localparam int SW = FRAC_WIDTH + 1;

  logic [SW-1:0] sum;

  // One-bit quantizer: the overflow of residue plus input.
  assign sum      = {1'b0, resid_q} + {1'b0, frac};
  assign carry_nx = sum[SW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      resid_q <= '0;
    end else if (step) begin
      carry_q <= sum[SW-1];
      resid_q <= sum[FRAC_WIDTH-1:0];
    end
  end

  // R2: a carry occurs exactly when the residue wraps downward.
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (carry_q == (resid_q < $past(resid_q))));

  // R2: the carry and residue hold between period starts.
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(resid_q) && $stable(carry_q)));

  // R3: a zero fractional word never produces a carry.
  p_zero_frac_r3: assert property (@(posedge clk) disable iff (rst)
    (step && frac == '0) |=> !carry_q);
endmodule

// File: rtl/fdiv_count.sv
module fdiv_count #(
  parameter int N_WIDTH   = fdiv_pkg::DEF_N_WIDTH,
  parameter int HI_CYCLES = fdiv_pkg::DEF_HI_CYCLES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_WIDTH:0] len_in,
  output logic           term,
  output logic           div_q
);
  localparam int LW = N_WIDTH + 1;
  localparam logic [LW-1:0] ONE  = LW'(1);
  localparam logic [LW-1:0] HI_W = LW'(HI_CYCLES);

  logic [LW-1:0] pos;
  logic [LW-1:0] len;
  logic [LW-1:0] pos_nx;

  assign term   = (pos == len - ONE);
  assign pos_nx = term ? '0 : pos + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      len   <= ONE;
      div_q <= 1'b0;
    end else begin
      pos   <= pos_nx;
      div_q <= (pos_nx < HI_W);
      if (term) len <= len_in;
    end
  end

  // R1: the position never runs past the loaded period length.
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pos < len);

  // R6: every period starts with the output high.
  p_start_high_r6: assert property (@(posedge clk) disable iff (rst)
    term |=> div_q);
endmodule

// File: rtl/frac_modulus_divider.sv
module frac_modulus_divider #(
  parameter int N_WIDTH    = fdiv_pkg::DEF_N_WIDTH,
  parameter int FRAC_WIDTH = fdiv_pkg::DEF_FRAC_WIDTH,
  parameter int HI_CYCLES  = fdiv_pkg::DEF_HI_CYCLES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_WIDTH-1:0]    n_int,
  input  logic [FRAC_WIDTH-1:0] x_frac,
  output logic                  div_clk,
  output logic                  mod_sel,
  output logic [FRAC_WIDTH-1:0] phase_res
);
  localparam int LW = N_WIDTH + 1;

  logic          term;
  logic          carry_nx;
  logic [LW-1:0] len_next;

  // Length of the coming period: N, or N+1 on an accumulator carry.
  assign len_next = {1'b0, n_int} + LW'(carry_nx);

  fdiv_accum #(.FRAC_WIDTH(FRAC_WIDTH)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .step     (term),
    .frac     (x_frac),
    .carry_nx (carry_nx),
    .carry_q  (mod_sel),
    .resid_q  (phase_res)
  );

  fdiv_count #(.N_WIDTH(N_WIDTH), .HI_CYCLES(HI_CYCLES)) u_count (
    .clk    (clk),
    .rst    (rst),
    .len_in (len_next),
    .term   (term),
    .div_q  (div_clk)
  );

  // R7: the modulus bit moves only at a period start.
  p_mod_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    (mod_sel != $past(mod_sel)) |-> $rose(div_clk));
endmodule

// File: tb/frac_modulus_divider_tb.sv
module frac_modulus_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int MW = 4;
  localparam int HI = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0] n_in = NW'(5);
  logic [MW-1:0] x_in = '0;
  logic div_o, mod_o;
  logic [MW-1:0] res_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_modulus_divider #(.N_WIDTH(NW), .FRAC_WIDTH(MW), .HI_CYCLES(HI)) u_dut (
    .clk(clk), .rst(rst), .n_int(n_in), .x_frac(x_in),
    .div_clk(div_o), .mod_sel(mod_o), .phase_res(res_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs as seen by each rising edge.
  logic [NW-1:0] n_s;
  logic [MW-1:0] x_s;
  logic r_s = 1'b1;
  always @(posedge clk) begin
    n_s <= n_in;
    x_s <= x_in;
    r_s <= rst;
  end

  // Reference model, evaluated mid-cycle.
  int res_m = 0, car_m = 0, len_m = 0, cyc = 0, hic = 0;
  bit prev = 0, started = 0, was_rst = 1;
  always @(negedge clk) begin
    if (r_s) begin
      check(div_o == 0 && mod_o == 0 && res_o == 0, "R8 reset outputs",
            {div_o, mod_o, res_o}, 0);
      res_m = 0; car_m = 0; prev = 0; started = 0; was_rst = 1;
    end else begin
      if (was_rst) check(div_o == 1, "R8 first period start", div_o, 1);
      was_rst = 0;
      if (div_o && !prev) begin
        if (started) begin
          check(cyc == len_m, "R1/R7 period length", cyc, len_m);
          check(hic == HI, "R6 high time", hic, HI);
        end
        begin
          int s;
          s = res_m + int'(x_s);
          car_m = s >> MW;
          res_m = s % (1 << MW);
        end
        len_m = int'(n_s) + car_m;
        if (x_s == 0) check(mod_o == 0, "R3 no carry at x=0", mod_o, 0);
        cyc = 1; hic = 1; started = 1;
      end else begin
        cyc++;
        if (div_o) hic++;
      end
      check(mod_o == car_m[0] && int'(res_o) == res_m, "R2 carry/residue",
            {mod_o, res_o}, car_m * (1 << MW) + res_m);
    end
    prev = div_o;
  end

  task automatic wait_rise();
    logic pv;
    pv = div_o;
    forever begin
      @(negedge clk);
      if (div_o && !pv) break;
      pv = div_o;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd7);
    // R5: quarter fraction from reset.
    n_in = NW'(5); x_in = MW'(4);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wait_rise();
      check(mod_o == ((k % 4) == 3), "R5 carry pattern", mod_o, (k % 4) == 3);
    end
    // R3: integer-only operation.
    x_in = '0; n_in = NW'(7);
    wait_rise();
    begin
      int cs = 0;
      for (int k = 0; k < 10; k++) begin wait_rise(); cs += mod_o; end
      check(cs == 0, "R3 carry count", cs, 0);
    end
    // R4: exact average over 2^m periods.
    x_in = MW'(11); n_in = NW'(9);
    wait_rise();
    begin
      int tot = 0, rises = 0;
      logic pv;
      pv = div_o;
      while (rises < 16) begin
        @(negedge clk);
        tot++;
        if (div_o && !pv) rises++;
        pv = div_o;
      end
      check(tot == 16 * 9 + 11, "R4 total length", tot, 16 * 9 + 11);
    end
    // R7: mid-period change must wait for the next period.
    x_in = MW'(3); n_in = NW'(6);
    wait_rise();
    @(negedge clk); @(negedge clk);
    n_in = NW'(12); x_in = MW'(15);
    wait_rise(); wait_rise();
    // Mixed random stimulus inside the legal range (R9).
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(4) == 0) begin
        n_in = NW'($urandom_range(HI + 12, HI + 1));
        x_in = MW'($urandom_range((1 << MW) - 1));
      end
    end
    // R8: mid-run reset.
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule